// File: doc/BRIEF.md
# RAID6 P/Q Syndrome Engine

This block computes the two RAID6 parity bytes for one byte position of a stripe. Data bytes arrive one per beat on a valid/ready stream, and each beat carries the index of the slot it came from. P is the XOR of the accepted bytes. Q is the GF(2^8) sum of each byte multiplied by g^i, where i is the slot index and g = 0x02. The field is reduced by the polynomial 0x11d. A beat flagged as last closes the stripe byte, and the block then presents P and Q with a one-cycle valid pulse.

Slots that are absent are simply never presented. Every byte that is presented keeps the coefficient of its own slot index, so the gaps have no effect on the other terms. Each pass begins with a start pulse, and the output of P and of Q can each be disabled for that pass. Requesting both disables is rejected. If a source list is longer than one pass should carry, it can be split across passes. The first pass starts from zero. Each later pass starts in continue mode and seeds its accumulators with the P and Q that the previous pass produced.

Top module: `rdx_pq_syndrome`

## Requirements
- R1: Multiplication is in GF(2^8) reduced by 0x11d. Multiplying by 0x02 shifts left one bit, and XORs in 0x1d when bit 7 was set, so g^8 = 0x1d.
- R2: Q is the XOR over accepted beats of in_data multiplied by g^in_idx. The coefficient comes from the presented index, and skipped indices leave the other terms unchanged.
- R3: P is the XOR of all accepted in_data bytes of the pass.
- R4: out_valid is high for exactly one cycle, the cycle after the edge that accepts a beat with in_last set. It is returned together with out_p and out_q. in_ready is high only while a pass is running.
- R5: A start with cont low clears both accumulators before the first beat.
- R6: A start with cont high loads seed_p and seed_q into the accumulators. A pass split into groups therefore gives the same P and Q as one single pass.
- R7: With dis_p latched at start, out_p reads 0x00. With dis_q latched, out_q reads 0x00. The other output is unaffected.
- R8: A start with dis_p and dis_q both high raises err_mode for one cycle and starts no pass, so in_ready stays low.
- R9: The total slot count, P and Q included, is at most MAX_SLOTS = 255, so data indices above 252 are illegal. Such a beat is consumed and contributes nothing to P or Q, and err_idx pulses in the next cycle.
- R10: A start pulse while a pass is running is ignored.
- R11: Synchronous active-high reset clears out_valid, out_p, out_q, the error flags and in_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (honoured only when idle) |
| cont | input | 1 | With start: seed accumulators instead of clearing |
| dis_p | input | 1 | With start: suppress P for this pass |
| dis_q | input | 1 | With start: suppress Q for this pass |
| seed_p | input | 8 | P seed for continue mode |
| seed_q | input | 8 | Q seed for continue mode |
| in_valid | input | 1 | Data beat valid |
| in_ready | output | 1 | Engine accepting beats (pass running) |
| in_idx | input | IDXW | Slot index of the beat |
| in_data | input | 8 | Data byte |
| in_last | input | 1 | Final beat of the stripe byte |
| out_valid | output | 1 | One-cycle result strobe |
| out_p | output | 8 | P result |
| out_q | output | 8 | Q result |
| err_mode | output | 1 | Pulse: start with both outputs disabled |
| err_idx | output | 1 | Pulse: beat with an illegal slot index |

## Verification
The sweeps cover every legal slot index with one source each, and every data value on an index whose coefficient needs reduction. A wrong coefficient entry, a wrong reduction term or a bad accumulator bit therefore shows up in out_q or out_p at the first result strobe that touches it, one cycle after the last beat. Stale accumulator state from an earlier pass, whether from a missing clear or a wrong seed, corrupts the first result of the next pass. Split passes are compared against the single-pass value, so any state lost across the seed boundary also shows in the result.

// File: rtl/rdx_pq_pkg.sv
package rdx_pq_pkg;
  typedef logic [7:0] gf_t;

  // multiply by the generator element 0x02 with reduction
  function automatic gf_t gf_xtime(input gf_t a, input gf_t red);
    gf_t s;
    s = {a[6:0], 1'b0};
    return a[7] ? (s ^ red) : s;
  endfunction

  // full GF(2^8) product, shift-and-add from the low bit of b
  function automatic gf_t gf_mul(input gf_t a, input gf_t b, input gf_t red);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh, red);
    end
    return acc;
  endfunction

  // g^n for g = 0x02
  function automatic gf_t gf_pow2(input int n, input gf_t red);
    gf_t r;
    r = 8'h01;
    for (int k = 0; k < n; k++) r = gf_xtime(r, red);
    return r;
  endfunction
endpackage

// File: rtl/rdx_gf_pow_rom.sv
module rdx_gf_pow_rom #(
  parameter int         IDXW = 8,
  parameter logic [8:0] POLY = 9'h11d
) (
  input  logic [IDXW-1:0] idx,
  output logic [7:0]      coef
);
  import rdx_pq_pkg::*;
  localparam int DEPTH = 1 << IDXW;

  gf_t tbl [DEPTH];

  // constant table of g^i, computed at elaboration
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam gf_t VAL = gf_pow2(i, POLY[7:0]);
    assign tbl[i] = VAL;
  end

  assign coef = tbl[idx];
endmodule

// File: rtl/rdx_gf_mul.sv
module rdx_gf_mul #(
  parameter logic [8:0] POLY = 9'h11d
) (
  input  logic [7:0] a,
  input  logic [7:0] b,
  output logic [7:0] p
);
  import rdx_pq_pkg::*;

  assign p = gf_mul(a, b, POLY[7:0]);

  // field identities the product must respect (R1)
  always_comb begin
    if (b == 8'h01) assert_mul_one_R1: assert (p == a);
    if (a == 8'h00) assert_mul_zero_R1: assert (p == 8'h00);
  end
endmodule

// File: rtl/rdx_pq_accum.sv
module rdx_pq_accum #(
  parameter int         IDXW = 8,
  parameter logic [8:0] POLY = 9'h11d
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            seed_ld,
  input  logic [7:0]      seed_p,
  input  logic [7:0]      seed_q,
  input  logic            beat_en,
  input  logic [IDXW-1:0] idx,
  input  logic [7:0]      data,
  output logic [7:0]      acc_p,
  output logic [7:0]      acc_q,
  output logic [7:0]      nxt_p,
  output logic [7:0]      nxt_q
);
  logic [7:0] coef;
  logic [7:0] term;

  rdx_gf_pow_rom #(.IDXW(IDXW), .POLY(POLY)) u_rom (.idx(idx), .coef(coef));
  rdx_gf_mul     #(.POLY(POLY))              u_mul (.a(data), .b(coef), .p(term));

  assign nxt_p = beat_en ? (acc_p ^ data) : acc_p;
  assign nxt_q = beat_en ? (acc_q ^ term) : acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_p <= '0;
      acc_q <= '0;
    end else if (seed_ld) begin
      acc_p <= seed_p;
      acc_q <= seed_q;
    end else begin
      acc_p <= nxt_p;
      acc_q <= nxt_q;
    end
  end
endmodule

// File: rtl/rdx_pq_syndrome.sv
module rdx_pq_syndrome #(
  parameter int         IDXW      = 8,
  parameter int         MAX_SLOTS = 255,
  parameter logic [8:0] POLY      = 9'h11d
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            cont,
  input  logic            dis_p,
  input  logic            dis_q,
  input  logic [7:0]      seed_p,
  input  logic [7:0]      seed_q,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IDXW-1:0] in_idx,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            out_valid,
  output logic [7:0]      out_p,
  output logic [7:0]      out_q,
  output logic            err_mode,
  output logic            err_idx
);
  localparam int              MAX_DATA = MAX_SLOTS - 2;
  localparam logic [IDXW-1:0] TOP_IDX  = IDXW'(MAX_DATA - 1);

  logic       running;
  logic       cfg_dis_p, cfg_dis_q;
  logic       beat, idx_ok, take, go, both_off, launch, closing;
  logic [7:0] acc_p, acc_q, nxt_p, nxt_q;

  assign in_ready = running;
  assign beat     = in_valid & running;
  assign idx_ok   = (in_idx <= TOP_IDX);
  assign take     = beat & idx_ok;
  assign closing  = beat & in_last;
  assign go       = start & ~running;
  assign both_off = dis_p & dis_q;
  assign launch   = go & ~both_off;

  rdx_pq_accum #(.IDXW(IDXW), .POLY(POLY)) u_acc (
    .clk(clk), .rst(rst),
    .clear(launch & ~cont), .seed_ld(launch & cont),
    .seed_p(seed_p), .seed_q(seed_q),
    .beat_en(take), .idx(in_idx), .data(in_data),
    .acc_p(acc_p), .acc_q(acc_q), .nxt_p(nxt_p), .nxt_q(nxt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      cfg_dis_p <= 1'b0;
      cfg_dis_q <= 1'b0;
      out_valid <= 1'b0;
      out_p     <= '0;
      out_q     <= '0;
      err_mode  <= 1'b0;
      err_idx   <= 1'b0;
    end else begin
      err_mode  <= go & both_off;
      err_idx   <= beat & ~idx_ok;
      out_valid <= closing;
      if (launch) begin
        running   <= 1'b1;
        cfg_dis_p <= dis_p;
        cfg_dis_q <= dis_q;
      end else if (closing) begin
        running <= 1'b0;
      end
      if (closing) begin
        out_p <= cfg_dis_p ? 8'h00 : nxt_p;
        out_q <= cfg_dis_q ? 8'h00 : nxt_q;
      end
    end
  end

  assert_out_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_idle_on_result_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  assert_clear_on_start_R5: assert property (@(posedge clk) disable iff (rst)
    (start && !in_ready && !cont && !(dis_p && dis_q)) |=> (acc_p == 8'h00 && acc_q == 8'h00));
  assert_seed_on_cont_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !in_ready && cont && !(dis_p && dis_q))
      |=> (acc_p == $past(seed_p) && acc_q == $past(seed_q)));
  assert_p_off_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_dis_p) |-> (out_p == 8'h00));
  assert_q_off_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_dis_q) |-> (out_q == 8'h00));
  assert_mode_reject_R8: assert property (@(posedge clk) disable iff (rst)
    err_mode |-> !in_ready);
  assert_bad_index_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_idx > TOP_IDX) |=> err_idx);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (start && in_ready && !(in_valid && in_last)) |=> in_ready);
endmodule

// File: tb/tb_rdx_pq_syndrome.sv
module tb_rdx_pq_syndrome;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 0, cont = 0, dis_p = 0, dis_q = 0;
  logic [7:0] seed_p = 0, seed_q = 0;
  logic       in_valid = 0, in_last = 0;
  logic [7:0] in_idx = 0, in_data = 0;
  logic       in_ready, out_valid, err_mode, err_idx;
  logic [7:0] out_p, out_q;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rdx_pq_syndrome dut (
    .clk(clk), .rst(rst), .start(start), .cont(cont), .dis_p(dis_p), .dis_q(dis_q),
    .seed_p(seed_p), .seed_q(seed_q), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_p(out_p), .out_q(out_q), .err_mode(err_mode), .err_idx(err_idx)
  );

  // reference arithmetic: Horner-style product from the top bit of b
  function automatic logic [7:0] dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1d) : (a << 1);
  endfunction
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    for (int k = 7; k >= 0; k--) begin
      r = dbl(r);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction
  function automatic logic [7:0] ref_pow(input int n);
    logic [7:0] r = 8'h01;
    for (int k = 0; k < n; k++) r = ref_mul(r, 8'h02);
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic begin_pass(input logic c, input logic dp, input logic dq,
                            input logic [7:0] sp, input logic [7:0] sq);
    @(negedge clk);
    start = 1; cont = c; dis_p = dp; dis_q = dq; seed_p = sp; seed_q = sq;
    @(negedge clk);
    start = 0; cont = 0; dis_p = 0; dis_q = 0;
  endtask

  // drives one beat; returns at the negedge after the accepting edge
  task automatic send(input logic [7:0] idx, input logic [7:0] d, input logic last);
    in_valid = 1; in_idx = idx; in_data = d; in_last = last;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ep, eq, p1, q1, d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 in_ready", {7'd0, in_ready}, 8'd0);
    chk("R11 out_valid", {7'd0, out_valid}, 8'd0);
    chk("R11 out_p", out_p, 8'd0);
    chk("R11 out_q", out_q, 8'd0);

    // R2/R3 single source on every legal index
    for (int i = 0; i < 253; i++) begin
      d = 8'(i * 7 + 3);
      begin_pass(0, 0, 0, 0, 0);
      send(8'(i), d, 1);
      chk("R4 out_valid", {7'd0, out_valid}, 8'd1);
      chk("R3 P single", out_p, d);
      chk("R2 Q single", out_q, ref_mul(d, ref_pow(i)));
      @(negedge clk);
      chk("R4 pulse ends", {7'd0, out_valid}, 8'd0);
    end

    // R1 every data value on index 8 (coefficient 0x1d)
    chk("R1 g^8", ref_pow(8), 8'h1d);
    for (int v = 0; v < 256; v++) begin
      begin_pass(0, 0, 0, 0, 0);
      send(8'd8, 8'(v), 1);
      chk("R1 Q reduction", out_q, ref_mul(8'(v), 8'h1d));
    end

    // R2 sparse slots keep their own coefficients
    begin_pass(0, 0, 0, 0, 0);
    chk("R4 ready in pass", {7'd0, in_ready}, 8'd1);
    ep = 0; eq = 0;
    foreach (ep[k]) ; // no-op keeps ep/eq typed
    begin
      int ids [5] = '{0, 2, 5, 9, 200};
      int ds  [5] = '{8'h11, 8'hf0, 8'h80, 8'h3c, 8'hc5};
      for (int k = 0; k < 5; k++) begin
        ep = ep ^ 8'(ds[k]);
        eq = eq ^ ref_mul(8'(ds[k]), ref_pow(ids[k]));
        send(8'(ids[k]), 8'(ds[k]), k == 4);
      end
    end
    chk("R3 P sparse", out_p, ep);
    chk("R2 Q sparse", out_q, eq);

    // R6 split across two passes equals a single pass; R5 fresh start
    ep = 0; eq = 0;
    for (int k = 0; k < 8; k++) begin
      ep = ep ^ 8'(k * 37 + 1);
      eq = eq ^ ref_mul(8'(k * 37 + 1), ref_pow(k * 3));
    end
    begin_pass(0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) send(8'(k * 3), 8'(k * 37 + 1), k == 3);
    p1 = out_p; q1 = out_q;
    begin_pass(1, 0, 0, p1, q1);
    for (int k = 4; k < 8; k++) send(8'(k * 3), 8'(k * 37 + 1), k == 7);
    chk("R6 P continued", out_p, ep);
    chk("R6 Q continued", out_q, eq);
    begin_pass(0, 0, 0, 0, 0);
    send(8'd1, 8'h42, 1);
    chk("R5 P cleared", out_p, 8'h42);
    chk("R5 Q cleared", out_q, ref_mul(8'h42, 8'h02));

    // R7 independent disables
    begin_pass(0, 1, 0, 0, 0);
    send(8'd3, 8'h5a, 0); send(8'd4, 8'h0f, 1);
    chk("R7 P disabled", out_p, 8'h00);
    chk("R7 Q kept", out_q, ref_mul(8'h5a, ref_pow(3)) ^ ref_mul(8'h0f, ref_pow(4)));
    begin_pass(0, 0, 1, 0, 0);
    send(8'd3, 8'h5a, 0); send(8'd4, 8'h0f, 1);
    chk("R7 P kept", out_p, 8'h55);
    chk("R7 Q disabled", out_q, 8'h00);

    // R8 both disabled is rejected
    @(negedge clk);
    start = 1; dis_p = 1; dis_q = 1;
    @(negedge clk);
    start = 0; dis_p = 0; dis_q = 0;
    chk("R8 err_mode", {7'd0, err_mode}, 8'd1);
    chk("R8 no pass", {7'd0, in_ready}, 8'd0);
    @(negedge clk);
    chk("R8 err pulse", {7'd0, err_mode}, 8'd0);

    // R9 illegal indices consumed without effect
    begin_pass(0, 0, 0, 0, 0);
    send(8'd1, 8'h21, 0);
    chk("R9 err clear", {7'd0, err_idx}, 8'd0);
    send(8'd253, 8'h99, 0);
    chk("R9 err_idx 253", {7'd0, err_idx}, 8'd1);
    send(8'd255, 8'h77, 0);
    chk("R9 err_idx 255", {7'd0, err_idx}, 8'd1);
    send(8'd252, 8'h06, 1);
    chk("R9 err cleared", {7'd0, err_idx}, 8'd0);
    chk("R9 P excl", out_p, 8'h21 ^ 8'h06);
    chk("R9 Q excl", out_q, ref_mul(8'h21, 8'h02) ^ ref_mul(8'h06, ref_pow(252)));

    // R10 start during a pass is ignored
    begin_pass(0, 0, 0, 0, 0);
    send(8'd0, 8'h13, 0);
    begin_pass(1, 1, 0, 8'hff, 8'hff);
    chk("R10 still running", {7'd0, in_ready}, 8'd1);
    send(8'd6, 8'h24, 1);
    chk("R10 P intact", out_p, 8'h13 ^ 8'h24);
    chk("R10 Q intact", out_q, 8'h13 ^ ref_mul(8'h24, ref_pow(6)));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule